// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack and Interrupt Entry

This block owns the instruction address of a small soft processor whose every instruction occupies one machine cycle of four clocks. A free-running four-state phase counter paces the cycle. The program counter and the interrupt-enable bit change only at the clock edge that closes the fourth phase. At that edge the block takes the control strobes that the instruction decoder holds for the whole cycle, and then it steps, skips, jumps, calls or returns.

Calls and interrupt entries push a return address into a small hardware stack, and returns pop it. When too many addresses are pushed, the stack wraps around and overwrites the oldest entry, and a sticky overflow flag goes high. The external interrupt is active high and level sensitive. It is looked at only at the closing edge of the machine cycle. When it is accepted, the instruction of that cycle is dropped, its own address is saved, and execution goes to a fixed vector. Further interrupts are then blocked until the return-from-interrupt strobe.

Top module: `pc_sequencer`

## Requirements
- R1: After reset the program address is 0, the phase output is 0, the overflow flag is low and interrupts are enabled.
- R2: The phase output counts 0,1,2,3,0,... by one on every clock. The program address changes only at the edge that ends phase 3.
- R3: With no strobe active, each machine cycle adds 1 to the address, and the address wraps from 2047 to 0 (11-bit address).
- R4: A skip request alone adds 2 to the address, modulo 2048.
- R5: A goto strobe loads the 11-bit jump target.
- R6: A call strobe loads the jump target and pushes the address of the call plus 1.
- R7: A return strobe loads the most recently pushed address and removes it from the stack. The return-from-interrupt strobe does the same and also enables interrupts again.
- R8: An interrupt is accepted only when the line is high at the edge that ends phase 3 and interrupts are enabled. A line that is high only during phases 0 to 2 has no effect. On entry the address becomes 4, the current address is pushed, and interrupts are disabled.
- R9: While interrupts are disabled a high line is ignored. If the line is still high when the return-from-interrupt completes, the service routine is entered again in the very next machine cycle.
- R10: The stack holds 8 entries. A push onto a full stack overwrites the oldest entry and sets the overflow flag, which then stays high until reset. The next 8 pops return the 8 newest addresses, newest first.
- R11: When several requests meet in one cycle, the priority is: interrupt entry, then goto, then call, then return / return-from-interrupt, then skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_goto | input | 1 | Decoded goto strobe, held for the machine cycle |
| op_call | input | 1 | Decoded call strobe |
| op_return | input | 1 | Decoded return-from-subroutine strobe |
| op_retfie | input | 1 | Decoded return-from-interrupt strobe |
| skip_req | input | 1 | Skip the next instruction |
| jump_target | input | 11 | Target of goto and call |
| irq | input | 1 | External interrupt, active high, level sensitive |
| pc_addr | output | 11 | Current program address |
| stk_ovf | output | 1 | Sticky stack overflow flag |
| phase | output | 2 | Current phase of the machine cycle, 0 to 3 |

## Verification
The bench sweeps goto targets across the whole address space and follows each with a skip. It drives increments and skips across the 2047-to-0 boundary, where a design that carries out of 11 bits would go wrong. It nests calls from one to eight levels deep and unwinds them, then pushes past the eighth level: a pointer that failed to wrap or a flag that cleared itself would return the wrong addresses or lose the overflow indication. The interrupt is driven in every phase except the last to catch a design that samples it too early. It is also held high through the service routine and past its return, which exposes an enable bit that is not cleared on entry or not restored by the return. Combined strobes check that the interrupt drops the instruction it preempts.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

    typedef enum logic [1:0] {
        PH_0 = 2'd0,
        PH_1 = 2'd1,
        PH_2 = 2'd2,
        PH_3 = 2'd3
    } phase_e;

    typedef enum logic [2:0] {
        ACT_STEP,
        ACT_SKIP,
        ACT_JUMP,
        ACT_CALL,
        ACT_POP,
        ACT_TRAP
    } act_e;

endpackage

// File: rtl/pc_phase_ctr.sv
module pc_phase_ctr
    import pc_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase_o,
    output logic   commit_o
);

    typedef struct packed {
        phase_e ph;
    } ph_state_t;

    ph_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ph = phase_e'(st_q.ph + 2'd1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_0};
        else        st_q <= st_d;
    end

    assign phase_o  = st_q.ph;
    assign commit_o = (st_q.ph == PH_3);

endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] push_data_i,
    output logic [W-1:0] top_o,
    output logic         ovf_o
);

    localparam int SP_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [SP_W-1:0]  SP_LAST  = SP_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [SP_W-1:0]         sp;
        logic [CNT_W-1:0]        cnt;
        logic                    ovf;
    } stk_state_t;

    stk_state_t      st_d, st_q;
    logic [SP_W-1:0] sp_up, sp_dn;

    always_comb begin
        sp_up = (st_q.sp == SP_LAST) ? '0 : st_q.sp + SP_W'(1);
        sp_dn = (st_q.sp == '0) ? SP_LAST : st_q.sp - SP_W'(1);
        st_d  = st_q;
        if (push_i) begin
            st_d.mem[st_q.sp] = push_data_i;
            st_d.sp           = sp_up;
            if (st_q.cnt == CNT_FULL) st_d.ovf = 1'b1;
            else                      st_d.cnt = st_q.cnt + CNT_W'(1);
        end else if (pop_i && st_q.cnt != '0) begin
            st_d.sp  = sp_dn;
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign top_o = st_q.mem[sp_dn];
    assign ovf_o = st_q.ovf;

endmodule

// File: rtl/pc_next_sel.sv
module pc_next_sel
    import pc_seq_pkg::*;
#(
    parameter int PC_W     = 11,
    parameter int VEC_ADDR = 4
) (
    input  logic            commit_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic            ie_i,
    input  logic            goto_i,
    input  logic            call_i,
    input  logic            ret_i,
    input  logic            retfie_i,
    input  logic            skip_i,
    input  logic            irq_i,
    input  logic [PC_W-1:0] target_i,
    input  logic [PC_W-1:0] stack_top_i,
    output act_e            act_o,
    output logic [PC_W-1:0] pc_next_o,
    output logic            ie_next_o,
    output logic            push_o,
    output logic            pop_o,
    output logic [PC_W-1:0] push_data_o
);

    logic [PC_W-1:0] pc_inc1, pc_inc2;

    always_comb begin
        pc_inc1 = pc_i + PC_W'(1);
        pc_inc2 = pc_i + PC_W'(2);

        if (irq_i && ie_i)              act_o = ACT_TRAP;
        else if (goto_i)                act_o = ACT_JUMP;
        else if (call_i)                act_o = ACT_CALL;
        else if (ret_i || retfie_i)     act_o = ACT_POP;
        else if (skip_i)                act_o = ACT_SKIP;
        else                            act_o = ACT_STEP;

        pc_next_o   = pc_inc1;
        ie_next_o   = ie_i;
        push_o      = 1'b0;
        pop_o       = 1'b0;
        push_data_o = pc_inc1;

        unique case (act_o)
            ACT_TRAP: begin
                pc_next_o   = PC_W'(VEC_ADDR);
                ie_next_o   = 1'b0;
                push_o      = commit_i;
                push_data_o = pc_i;
            end
            ACT_JUMP: pc_next_o = target_i;
            ACT_CALL: begin
                pc_next_o = target_i;
                push_o    = commit_i;
            end
            ACT_POP: begin
                pc_next_o = stack_top_i;
                pop_o     = commit_i;
                if (retfie_i) ie_next_o = 1'b1;
            end
            ACT_SKIP: pc_next_o = pc_inc2;
            default:  pc_next_o = pc_inc1;
        endcase
    end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pc_seq_pkg::*;
#(
    parameter int PC_W        = 11,
    parameter int STACK_DEPTH = 8,
    parameter int VEC_ADDR    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_goto,
    input  logic            op_call,
    input  logic            op_return,
    input  logic            op_retfie,
    input  logic            skip_req,
    input  logic [PC_W-1:0] jump_target,
    input  logic            irq,
    output logic [PC_W-1:0] pc_addr,
    output logic            stk_ovf,
    output logic [1:0]      phase
);

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            ie;
    } seq_state_t;

    seq_state_t      st_d, st_q;
    phase_e          ph;
    logic            commit;
    act_e            act;
    logic [PC_W-1:0] pc_next, push_data, stack_top;
    logic            ie_next, push, pop;
    logic            irq_en;

    pc_phase_ctr i_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_o  (ph),
        .commit_o (commit)
    );

    pc_next_sel #(
        .PC_W     (PC_W),
        .VEC_ADDR (VEC_ADDR)
    ) i_next (
        .commit_i    (commit),
        .pc_i        (st_q.pc),
        .ie_i        (st_q.ie),
        .goto_i      (op_goto),
        .call_i      (op_call),
        .ret_i       (op_return),
        .retfie_i    (op_retfie),
        .skip_i      (skip_req),
        .irq_i       (irq),
        .target_i    (jump_target),
        .stack_top_i (stack_top),
        .act_o       (act),
        .pc_next_o   (pc_next),
        .ie_next_o   (ie_next),
        .push_o      (push),
        .pop_o       (pop),
        .push_data_o (push_data)
    );

    pc_ret_stack #(
        .DEPTH (STACK_DEPTH),
        .W     (PC_W)
    ) i_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .pop_i       (pop),
        .push_data_i (push_data),
        .top_o       (stack_top),
        .ovf_o       (stk_ovf)
    );

    always_comb begin
        st_d = st_q;
        if (commit) begin
            st_d.pc = pc_next;
            st_d.ie = ie_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pc: '0, ie: 1'b1};
        else        st_q <= st_d;
    end

    assign pc_addr = st_q.pc;
    assign phase   = ph;
    assign irq_en  = st_q.ie;

endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
    parameter int PC_W     = 11,
    parameter int VEC_ADDR = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      phase,
    input logic [PC_W-1:0] pc_addr,
    input logic            stk_ovf,
    input logic            op_goto,
    input logic            op_call,
    input logic            op_return,
    input logic            op_retfie,
    input logic            skip_req,
    input logic [PC_W-1:0] jump_target,
    input logic            irq,
    input logic            ie
);

    logic closing;
    assign closing = (phase == 2'd3);

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> phase == $past(phase) + 2'd1);

    // R2
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !closing |=> $stable(pc_addr));

    // R5
    goto_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (closing && op_goto && !(irq && ie)) |=> pc_addr == $past(jump_target));

    // R4
    skip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (closing && skip_req && !op_goto && !op_call && !op_return && !op_retfie && !(irq && ie))
        |=> pc_addr == PC_W'($past(pc_addr) + PC_W'(2)));

    // R8
    irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (closing && irq && ie) |=> (pc_addr == PC_W'(VEC_ADDR) && !ie));

    // R9
    ie_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie && !(closing && op_retfie)) |=> !ie);

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_ovf |=> stk_ovf);

endmodule

bind pc_sequencer pc_sequencer_chk #(
    .PC_W     (PC_W),
    .VEC_ADDR (VEC_ADDR)
) i_pc_sequencer_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase       (phase),
    .pc_addr     (pc_addr),
    .stk_ovf     (stk_ovf),
    .op_goto     (op_goto),
    .op_call     (op_call),
    .op_return   (op_return),
    .op_retfie   (op_retfie),
    .skip_req    (skip_req),
    .jump_target (jump_target),
    .irq         (irq),
    .ie          (irq_en)
);

// File: tb/test_pc_sequencer.sv
module test_pc_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 11;
    localparam int DEPTH      = 8;
    localparam logic [W-1:0] VEC = 11'd4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_goto = 0, op_call = 0, op_return = 0, op_retfie = 0, skip_req = 0, irq = 0;
    logic [W-1:0] jump_target = '0;
    logic [W-1:0] pc_addr;
    logic         stk_ovf;
    logic [1:0]   phase;

    int n_chk = 0;
    int n_err = 0;

    logic [W-1:0] m_pc;
    logic [W-1:0] m_stk[$];
    bit           m_ie, m_ovf;

    pc_sequencer i_pc_sequencer (
        .clk(clk), .rst_n(rst_n), .op_goto(op_goto), .op_call(op_call),
        .op_return(op_return), .op_retfie(op_retfie), .skip_req(skip_req),
        .jump_target(jump_target), .irq(irq), .pc_addr(pc_addr),
        .stk_ovf(stk_ovf), .phase(phase)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic m_push(input logic [W-1:0] a);
        m_stk.push_back(a);
        if (m_stk.size() > DEPTH) begin
            void'(m_stk.pop_front());
            m_ovf = 1'b1;
        end
    endtask

    // one machine cycle; irq_mask[k] is the irq level during phase k
    task automatic run_op(input bit g, input bit c, input bit r, input bit rf, input bit s,
                          input logic [W-1:0] t, input logic [3:0] irq_mask, input string req);
        logic [W-1:0] old_pc;
        old_pc = m_pc;
        op_goto = g; op_call = c; op_return = r; op_retfie = rf; skip_req = s;
        jump_target = t; irq = irq_mask[0];
        if (irq_mask[3] && m_ie) begin
            m_push(m_pc); m_pc = VEC; m_ie = 1'b0;
        end else if (g) m_pc = t;
        else if (c) begin m_push(m_pc + W'(1)); m_pc = t; end
        else if (r || rf) begin
            if (m_stk.size() > 0) m_pc = m_stk.pop_back();
            if (rf) m_ie = 1'b1;
        end
        else if (s) m_pc = m_pc + W'(2);
        else m_pc = m_pc + W'(1);
        for (int k = 1; k < 4; k++) begin
            @(negedge clk);
            irq = irq_mask[k];
            chk(phase == 2'(k), "R2 phase", int'(phase), k);
            chk(pc_addr == old_pc, "R2 hold", int'(pc_addr), int'(old_pc));
        end
        @(negedge clk);
        chk(pc_addr == m_pc, req, int'(pc_addr), int'(m_pc));
        chk(stk_ovf == m_ovf, "R10 ovf", int'(stk_ovf), int'(m_ovf));
        chk(phase == 2'd0, "R2 phase wrap", int'(phase), 0);
    endtask

    task automatic step(input string req);
        run_op(0, 0, 0, 0, 0, '0, 4'b0000, req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [W-1:0] isr_ret;
        m_pc = '0; m_ie = 1'b1; m_ovf = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(pc_addr == 0, "R1 pc", int'(pc_addr), 0);
        chk(phase == 0, "R1 phase", int'(phase), 0);
        chk(stk_ovf == 0, "R1 ovf", int'(stk_ovf), 0);
        rst_n = 1'b1;
        // R3 sequential
        for (int i = 0; i < 20; i++) step("R3 step");
        // R5 goto sweep, R4 skip after each
        for (int t = 0; t < 2048; t += 97) begin
            run_op(1, 0, 0, 0, 0, W'(t), 4'b0000, "R5 goto");
            run_op(0, 0, 0, 0, 1, '0, 4'b0000, "R4 skip");
            step("R3 step");
        end
        // R3 / R4 wrap
        run_op(1, 0, 0, 0, 0, 11'd2046, 4'b0000, "R5 goto");
        step("R3 step");
        step("R3 wrap");
        run_op(1, 0, 0, 0, 0, 11'd2047, 4'b0000, "R5 goto");
        run_op(0, 0, 0, 0, 1, '0, 4'b0000, "R4 skip wrap");
        // R6 / R7 nested calls
        for (int d = 1; d <= DEPTH; d++) begin
            for (int i = 0; i < d; i++)
                run_op(0, 1, 0, 0, 0, W'(100 * i + 37 * d), 4'b0000, "R6 call");
            step("R3 step");
            for (int i = 0; i < d; i++)
                run_op(0, 0, 1, 0, 0, '0, 4'b0000, "R7 return");
        end
        // R11 priorities
        run_op(1, 1, 1, 0, 1, 11'd500, 4'b0000, "R11 goto first");
        run_op(0, 1, 1, 0, 1, 11'd700, 4'b0000, "R11 call over return");
        run_op(0, 0, 1, 0, 1, '0, 4'b0000, "R11 return over skip");
        // R8 irq only during phases 0..2 is ignored
        run_op(0, 0, 0, 0, 0, '0, 4'b0111, "R8 early irq ignored");
        // R8 accepted at phase 3; R11 goto dropped
        isr_ret = m_pc;
        run_op(1, 0, 0, 0, 0, 11'd900, 4'b1000, "R8 vector");
        // R9 held high inside routine: ignored
        run_op(0, 0, 0, 0, 0, '0, 4'b1111, "R9 masked");
        run_op(0, 0, 0, 0, 0, '0, 4'b1111, "R9 masked");
        run_op(0, 0, 0, 1, 0, '0, 4'b1111, "R7 retfie");
        chk(m_pc == isr_ret, "R7 resume", int'(m_pc), int'(isr_ret));
        run_op(0, 0, 0, 0, 0, '0, 4'b1111, "R9 reentry");
        run_op(0, 0, 0, 1, 0, '0, 4'b0000, "R7 retfie");
        step("R3 step");
        run_op(0, 1, 0, 0, 0, 11'd1200, 4'b1000, "R11 irq over call");
        run_op(0, 0, 0, 1, 0, '0, 4'b0000, "R7 retfie");
        // R10 overflow
        for (int i = 0; i < DEPTH + 2; i++)
            run_op(0, 1, 0, 0, 0, W'(300 + 11 * i), 4'b0000, "R10 deep call");
        for (int i = 0; i < DEPTH; i++)
            run_op(0, 0, 1, 0, 0, '0, 4'b0000, "R10 newest returned");
        step("R3 step");
        chk(stk_ovf == 1'b1, "R10 sticky", int'(stk_ovf), 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule